// File: doc/BRIEF.md
# Per-Bin Complex Weighting Matrix Engine

This block combines several frequency-domain sample streams into weighted partial sums for a set of destination channels. Each input stream carries two radio channels packed side by side in one 64-bit word, and the words on a stream arrive one FFT bin at a time. The block separates every input word into its two source channels. For each bin it multiplies every source by a complex weight chosen for that source, destination and bin. It then adds the products for each destination and sends the rounded, saturated results out two destinations per output stream.

Input streams may arrive with different delays. A small FIFO on each input absorbs the skew, and a set of words is consumed only when every FIFO holds at least one word. The bin number travels with stream 0. There are two weight banks. Software writes the standby bank through a single-word write port and then requests a swap. The swap takes effect at the next consumed bin 0, so a frame is always computed with one bank from start to end.

Top module: `dpe_top`

## Requirements
- R1: Input word bits [31:0] carry source channel 2i of stream i and bits [63:32] carry source 2i+1. A complex value is packed as real part in bits [31:16] and imaginary part in bits [15:0], both signed 16-bit.
- R2: A write with `cw_en` high stores `cw_data` as the weight of source `cw_src` toward destination `cw_dst` at bin `cw_bin`. The write goes into the standby bank and leaves the results of the active bank unchanged.
- R3: Each destination result equals the complex sum over all sources of sample times weight, with weights in Q1.15. Each component is rounded by adding 2^14 and shifting right arithmetically by 15, then saturated to the range -32768..32767.
- R4: A result appears exactly clog2(2·NUM_IN)+2 cycles after the cycle in which its set of input words is consumed. `out_bin` carries the bin that came with stream 0's word.
- R5: A set of words is consumed only in a cycle in which every input FIFO holds a word. A word that arrives while another stream is empty is held and not lost.
- R6: A pulse on `swap_req` arms a swap. The swap takes effect at the first consumed set whose bin is 0, and that set already uses the new bank. Sets with a nonzero bin keep using the old bank.
- R7: Output stream k carries destination 2k in bits [64k+31:64k] and destination 2k+1 in bits [64k+63:64k+32] of `out_data`.
- R8: A word pushed into a full FIFO that is not being read in the same cycle is dropped. `ovf_err` goes high the next cycle and stays high until reset.
- R9: During and right after reset, `out_valid` and `ovf_err` are low. Bank 0 is active after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Word present on each input stream |
| in_bin | input | clog2(BINS) | Bin number of the word on stream 0 |
| in_data | input | NUM_IN·64 | Two packed complex samples per stream |
| cw_en | input | 1 | Weight write strobe |
| cw_src | input | clog2(2·NUM_IN) | Source channel of the written weight |
| cw_dst | input | clog2(NUM_DST) | Destination channel of the written weight |
| cw_bin | input | clog2(BINS) | Bin of the written weight |
| cw_data | input | 32 | Complex weight, Q1.15 per component |
| swap_req | input | 1 | Arm a bank swap at the next bin 0 |
| out_valid | output | 1 | Result word valid |
| out_bin | output | clog2(BINS) | Bin of the result |
| out_data | output | NUM_DST·32 | Results packed in pairs of destinations |
| ovf_err | output | 1 | Sticky input FIFO overflow flag |

## Verification
The bench targets these cases:
- A swap armed in the middle of a frame. A design that flips banks immediately would corrupt the rest of that frame; one that never flips would keep old weights in the next frame.
- Streams that arrive skewed and with gaps. A design that consumes words before all streams are ready would pair words from different bins, which shows up as wrong sums or missing results.
- Full-scale samples with full-range weights, which drive the saturation path. Nonzero low bits in the sums test the rounding.
- A FIFO pushed past its depth. Here the dropped words must not appear, the flag must rise one cycle later and stay set, and the eight stored words must still come out matched in bin order.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int SW   = 16;      // bits per real or imaginary component
  localparam int FRAC = 15;      // weight fraction bits (Q1.15)
  localparam int CW   = 2 * SW;  // bits per complex value

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  function automatic logic signed [SW-1:0] re_of(input logic [CW-1:0] w);
    return signed'(w[CW-1:SW]);
  endfunction

  function automatic logic signed [SW-1:0] im_of(input logic [CW-1:0] w);
    return signed'(w[SW-1:0]);
  endfunction
endpackage

// File: rtl/dpe_align_fifo.sv
module dpe_align_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8      // power of two
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty,
  output logic         ovf
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CNTW-1:0] cnt;
  logic            full, wr_ok;

  assign full     = (cnt == CNTW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign wr_ok    = push && (!full || pop);
  assign ovf      = push && !wr_ok;
  assign dout     = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + PW'(1);
      if (pop)   rp <= rp + PW'(1);
      cnt <= cnt + CNTW'(wr_ok) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/dpe_coef_bank.sv
module dpe_coef_bank
  import dpe_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NDST = 4,
  parameter int BINS = 8      // power of two
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(NSRC)-1:0]   wsrc,
  input  logic [$clog2(NDST)-1:0]   wdst,
  input  logic [$clog2(BINS)-1:0]   wbin,
  input  logic [CW-1:0]             wdata,
  input  logic                      swap_req,
  input  logic                      fire,
  input  logic [$clog2(BINS)-1:0]   fire_bin,
  output logic [NSRC*NDST*CW-1:0]   coefs
);
  localparam int SRCW = $clog2(NSRC);
  localparam int DSTW = $clog2(NDST);

  logic live_q, pend_q, flip, sel;

  assign flip = pend_q && fire && (fire_bin == '0);
  assign sel  = live_q ^ flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (flip)     begin live_q <= ~live_q; pend_q <= 1'b0; end
      if (swap_req) pend_q <= 1'b1;
    end
  end

  // One small two-bank RAM per (source, destination) pair, addressed by {bank, bin}
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar d = 0; d < NDST; d++) begin : g_dst
      logic [CW-1:0] mem [2*BINS];
      always_ff @(posedge clk) begin
        if (we && wsrc == SRCW'(s) && wdst == DSTW'(d))
          mem[{~live_q, wbin}] <= wdata;
      end
      assign coefs[(s*NDST+d)*CW +: CW] = mem[{sel, fire_bin}];
    end
  end
endmodule

// File: rtl/dpe_dot_pipe.sv
module dpe_dot_pipe
  import dpe_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NDST = 4,
  parameter int BINS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_v,
  input  logic [$clog2(BINS)-1:0]   in_bin,
  input  logic [NSRC*CW-1:0]        smp,
  input  logic [NSRC*NDST*CW-1:0]   coefs,
  output logic                      out_v,
  output logic [$clog2(BINS)-1:0]   out_bin,
  output logic [NDST*CW-1:0]        out_data
);
  localparam int BW  = $clog2(BINS);
  localparam int LOG = $clog2(NSRC);
  localparam int NP  = 1 << LOG;
  localparam int AW  = 2*SW + 1 + LOG;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC-1);
  localparam logic signed [AW-1:0] MAXP = AW'((1 << (SW-1)) - 1);
  localparam logic signed [AW-1:0] MINN = -MAXP - AW'(1);

  function automatic logic [SW-1:0] rsat(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = (v + HALF) >>> FRAC;
    if (t > MAXP)      return MAXP[SW-1:0];
    else if (t < MINN) return MINN[SW-1:0];
    else               return t[SW-1:0];
  endfunction

  logic [LOG:0]  vsh;
  logic [BW-1:0] bsh [LOG+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vsh   <= '0;
      out_v <= 1'b0;
    end else begin
      vsh   <= {vsh[LOG-1:0], in_v};
      out_v <= vsh[LOG];
    end
  end

  always_ff @(posedge clk) begin
    bsh[0] <= in_bin;
    for (int k = 1; k <= LOG; k++) bsh[k] <= bsh[k-1];
    out_bin <= bsh[LOG];
  end

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    logic signed [AW-1:0] pr [NP];
    logic signed [AW-1:0] pq [NP];
    logic signed [AW-1:0] tr [LOG+1][NP];
    logic signed [AW-1:0] tq [LOG+1][NP];
    logic [CW-1:0]        res;

    always_comb begin
      for (int s = 0; s < NSRC; s++) begin
        pr[s] = AW'(re_of(smp[s*CW +: CW])) * AW'(re_of(coefs[(s*NDST+d)*CW +: CW]))
              - AW'(im_of(smp[s*CW +: CW])) * AW'(im_of(coefs[(s*NDST+d)*CW +: CW]));
        pq[s] = AW'(re_of(smp[s*CW +: CW])) * AW'(im_of(coefs[(s*NDST+d)*CW +: CW]))
              + AW'(im_of(smp[s*CW +: CW])) * AW'(re_of(coefs[(s*NDST+d)*CW +: CW]));
      end
      for (int s = NSRC; s < NP; s++) begin
        pr[s] = '0;
        pq[s] = '0;
      end
    end

    always_ff @(posedge clk) begin
      for (int s = 0; s < NP; s++) begin
        tr[0][s] <= pr[s];
        tq[0][s] <= pq[s];
      end
      for (int l = 1; l <= LOG; l++) begin
        for (int n = 0; n < (NP >> l); n++) begin
          tr[l][n] <= tr[l-1][2*n] + tr[l-1][2*n+1];
          tq[l][n] <= tq[l-1][2*n] + tq[l-1][2*n+1];
        end
      end
      res <= {rsat(tr[LOG][0]), rsat(tq[LOG][0])};
    end

    assign out_data[d*CW +: CW] = res;
  end
endmodule

// File: rtl/dpe_top.sv
module dpe_top
  import dpe_pkg::*;
#(
  parameter int NUM_IN     = 2,
  parameter int NUM_DST    = 4,   // even
  parameter int BINS       = 8,   // power of two
  parameter int FIFO_DEPTH = 8    // power of two
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IN-1:0]             in_valid,
  input  logic [$clog2(BINS)-1:0]       in_bin,
  input  logic [NUM_IN*2*CW-1:0]        in_data,
  input  logic                          cw_en,
  input  logic [$clog2(2*NUM_IN)-1:0]   cw_src,
  input  logic [$clog2(NUM_DST)-1:0]    cw_dst,
  input  logic [$clog2(BINS)-1:0]       cw_bin,
  input  logic [CW-1:0]                 cw_data,
  input  logic                          swap_req,
  output logic                          out_valid,
  output logic [$clog2(BINS)-1:0]       out_bin,
  output logic [NUM_DST*CW-1:0]         out_data,
  output logic                          ovf_err
);
  localparam int NSRC = 2 * NUM_IN;
  localparam int BW   = $clog2(BINS);
  localparam int FW   = BW + 2*CW;

  logic [NUM_IN-1:0]          nonempty, ovf;
  logic                       fire;
  logic [BW-1:0]              fire_bin;
  logic [NSRC*CW-1:0]         smp;
  logic [NSRC*NUM_DST*CW-1:0] coefs;

  assign fire = &nonempty;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    if (i == 0) begin : g_lead
      logic [FW-1:0] h;
      dpe_align_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(in_valid[i]),
        .din({in_bin, in_data[i*2*CW +: 2*CW]}), .pop(fire),
        .dout(h), .nonempty(nonempty[i]), .ovf(ovf[i]));
      assign fire_bin = h[FW-1:2*CW];
      assign smp[i*2*CW +: 2*CW] = h[2*CW-1:0];
    end else begin : g_rest
      logic [2*CW-1:0] h;
      dpe_align_fifo #(.W(2*CW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(in_valid[i]),
        .din(in_data[i*2*CW +: 2*CW]), .pop(fire),
        .dout(h), .nonempty(nonempty[i]), .ovf(ovf[i]));
      assign smp[i*2*CW +: 2*CW] = h;
    end
  end

  dpe_coef_bank #(.NSRC(NSRC), .NDST(NUM_DST), .BINS(BINS)) u_bank (
    .clk(clk), .rst(rst), .we(cw_en), .wsrc(cw_src), .wdst(cw_dst),
    .wbin(cw_bin), .wdata(cw_data), .swap_req(swap_req),
    .fire(fire), .fire_bin(fire_bin), .coefs(coefs));

  dpe_dot_pipe #(.NSRC(NSRC), .NDST(NUM_DST), .BINS(BINS)) u_pipe (
    .clk(clk), .rst(rst), .in_v(fire), .in_bin(fire_bin), .smp(smp),
    .coefs(coefs), .out_v(out_valid), .out_bin(out_bin), .out_data(out_data));

  always_ff @(posedge clk) begin
    if (rst)       ovf_err <= 1'b0;
    else if (|ovf) ovf_err <= 1'b1;
  end
endmodule

// File: rtl/dpe_chk.sv
module dpe_chk #(
  parameter int LAT    = 4,
  parameter int NUM_IN = 2,
  parameter int BW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              fire,
  input logic [BW-1:0]     fire_bin,
  input logic              live,
  input logic [NUM_IN-1:0] in_valid,
  input logic              out_valid,
  input logic              ovf_err
);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  a_r8_needs_push: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(in_valid != '0));

  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fire, LAT));

  a_r6_swap_at_bin0: assert property (@(posedge clk) disable iff (rst)
    !$stable(live) |-> $past(fire && fire_bin == '0));
endmodule

bind dpe_top dpe_chk #(
  .LAT($clog2(2*NUM_IN) + 2), .NUM_IN(NUM_IN), .BW($clog2(BINS))
) u_chk (
  .clk(clk), .rst(rst), .fire(fire), .fire_bin(fire_bin),
  .live(u_bank.live_q), .in_valid(in_valid), .out_valid(out_valid),
  .ovf_err(ovf_err));

// File: tb/test_dpe_top.sv
module test_dpe_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI  = 2;
  localparam int ND  = 4;
  localparam int NB  = 8;
  localparam int FD  = 8;
  localparam int S   = 2 * NI;
  localparam int LAT = $clog2(S) + 2;
  localparam int BW  = $clog2(NB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0]          in_valid = '0;
  logic [BW-1:0]          in_bin = '0;
  logic [NI*64-1:0]       in_data = '0;
  logic                   cw_en = 1'b0;
  logic [$clog2(S)-1:0]   cw_src = '0;
  logic [$clog2(ND)-1:0]  cw_dst = '0;
  logic [BW-1:0]          cw_bin = '0;
  logic [31:0]            cw_data = '0;
  logic                   swap_req = 1'b0;
  logic                   out_valid;
  logic [BW-1:0]          out_bin;
  logic [ND*32-1:0]       out_data;
  logic                   ovf_err;

  dpe_top #(.NUM_IN(NI), .NUM_DST(ND), .BINS(NB), .FIFO_DEPTH(FD)) i_dpe_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_data(in_data),
    .cw_en(cw_en), .cw_src(cw_src), .cw_dst(cw_dst), .cw_bin(cw_bin),
    .cw_data(cw_data), .swap_req(swap_req), .out_valid(out_valid),
    .out_bin(out_bin), .out_data(out_data), .ovf_err(ovf_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  int          cre [2][S][ND][NB];
  int          cim [2][S][ND][NB];
  logic [63:0] qd [NI][$];
  int          qb [$];
  int          live_m = 0, pend_m = 0, ovf_m = 0;
  bit          exp_v [32];
  int          exp_b [32];
  int          exp_re [32][ND];
  int          exp_im [32][ND];
  int          cyc = 0, errors = 0, checks = 0;
  string       tag = "R9";
  bit          done = 0;

  function automatic int rsat(longint v);
    longint t;
    t = (v + 16384) >>> 15;
    if (t > 32767)  return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic logic [15:0] r16(int amp);
    return 16'($urandom_range(0, 2*amp) - amp);
  endfunction

  function automatic logic [63:0] rword(int amp);
    return {r16(amp), r16(amp), r16(amp), r16(amp)};
  endfunction

  task automatic chk(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Compare this cycle, advance the model, then step one clock
  task automatic tick();
    int  slot, nslot, lv_old, sel, b;
    bit  fire;
    slot = cyc % 32;
    chk(tag, out_valid, exp_v[slot], "out_valid");
    if (exp_v[slot]) begin
      chk(tag, out_bin, exp_b[slot], "out_bin");
      for (int d = 0; d < ND; d++) begin
        chk(tag, $signed(out_data[d*32+16 +: 16]), exp_re[slot][d], "re");
        chk(tag, $signed(out_data[d*32 +: 16]), exp_im[slot][d], "im");
      end
    end
    chk(tag, ovf_err, ovf_m, "ovf_err");

    lv_old = live_m;
    fire = 1;
    for (int i = 0; i < NI; i++) if (qd[i].size() == 0) fire = 0;
    nslot = (cyc + LAT) % 32;
    exp_v[nslot] = 0;
    if (fire) begin
      b = qb[0];
      sel = live_m;
      if (pend_m != 0 && b == 0) begin
        sel = 1 - live_m; live_m = sel; pend_m = 0;
      end
      for (int d = 0; d < ND; d++) begin
        longint ar = 0, ai = 0;
        for (int s = 0; s < S; s++) begin
          logic [31:0] x;
          longint xr, xi;
          x  = (s % 2 == 1) ? qd[s/2][0][63:32] : qd[s/2][0][31:0];
          xr = longint'($signed(x[31:16]));
          xi = longint'($signed(x[15:0]));
          ar += xr * cre[sel][s][d][b] - xi * cim[sel][s][d][b];
          ai += xr * cim[sel][s][d][b] + xi * cre[sel][s][d][b];
        end
        exp_re[nslot][d] = rsat(ar);
        exp_im[nslot][d] = rsat(ai);
      end
      exp_v[nslot] = 1;
      exp_b[nslot] = b;
      for (int i = 0; i < NI; i++) void'(qd[i].pop_front());
      void'(qb.pop_front());
    end
    if (swap_req) pend_m = 1;
    if (cw_en) begin
      cre[1-lv_old][cw_src][cw_dst][cw_bin] = int'($signed(cw_data[31:16]));
      cim[1-lv_old][cw_src][cw_dst][cw_bin] = int'($signed(cw_data[15:0]));
    end
    for (int i = 0; i < NI; i++) begin
      if (in_valid[i]) begin
        if (qd[i].size() == FD) ovf_m = 1;
        else begin
          qd[i].push_back(in_data[i*64 +: 64]);
          if (i == 0) qb.push_back(int'(in_bin));
        end
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    in_valid = '0; cw_en = 0; swap_req = 0;
  endtask

  task automatic load_bank(int amp);
    for (int s = 0; s < S; s++)
      for (int d = 0; d < ND; d++)
        for (int b = 0; b < NB; b++) begin
          cw_en = 1; cw_src = s[$clog2(S)-1:0]; cw_dst = d[$clog2(ND)-1:0];
          cw_bin = b[BW-1:0]; cw_data = {r16(amp), r16(amp)};
          tick();
        end
  endtask

  task automatic frame(int amp, int swap_bin);
    for (int b = 0; b < NB; b++) begin
      in_valid = '1; in_bin = b[BW-1:0]; in_data = rword(amp);
      swap_req = (b == swap_bin);
      tick();
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) exp_v[k] = 0;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R9", out_valid, 0, "out_valid in reset");
      chk("R9", ovf_err, 0, "ovf_err in reset");
    end
    rst = 0;
    tag = "R9"; idle(2);

    // R2: fill standby bank with small weights, then swap (takes effect at bin 0)
    tag = "R2"; load_bank(4096);
    swap_req = 1; tick();
    idle(3);
    frame(3000, -1); idle(LAT + 2);

    // R1: each stream word has only one nonzero channel, alternating lanes
    tag = "R1";
    for (int b = 0; b < NB; b++) begin
      in_valid = '1; in_bin = b[BW-1:0];
      in_data = {rword(3000)[63:32], 32'h0, 32'h0, rword(3000)[31:0]};
      tick();
    end
    idle(LAT + 2);

    // R3 and R7: back-to-back frames
    tag = "R3"; frame(3000, -1); frame(12000, -1);
    tag = "R7"; frame(8000, -1); idle(LAT + 2);

    // R6: load full-range weights into standby, arm swap mid-frame at bin 3
    tag = "R6"; load_bank(32767);
    frame(3000, 3); frame(3000, -1); idle(LAT + 2);

    // R3: full-scale samples drive saturation
    tag = "R3"; frame(32767, -1); frame(32767, -1); idle(LAT + 2);

    // R4: gaps between sets
    tag = "R4";
    for (int b = 0; b < NB; b++) begin
      in_valid = '1; in_bin = b[BW-1:0]; in_data = rword(5000); tick();
      idle(b % 3);
    end
    idle(LAT + 2);

    // R5: skewed arrival, stream 0 first then stream 1 with gaps
    tag = "R5";
    for (int b = 0; b < 4; b++) begin
      in_valid = 2'b01; in_bin = b[BW-1:0]; in_data = rword(5000); tick();
    end
    idle(3);
    for (int b = 0; b < 4; b++) begin
      in_valid = 2'b10; in_data = rword(5000); tick(); idle(1);
    end
    idle(LAT + 2);

    // R8: overflow stream 0 while stream 1 is silent
    tag = "R8";
    for (int b = 0; b < FD + 2; b++) begin
      in_valid = 2'b01; in_bin = 3'(b % NB); in_data = rword(5000); tick();
    end
    chk("R8", ovf_err, 1, "flag after overflow");
    for (int b = 0; b < FD; b++) begin
      in_valid = 2'b10; in_data = rword(5000); tick();
    end
    idle(LAT + 4);
    chk("R8", ovf_err, 1, "flag sticky");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule